// File: doc/BRIEF.md
# Accuracy-Configurable Timing-Error Guard

This block sits beside one single-precision floating-point pipeline and decides, for each completed result, whether a replay is needed. The timing sensors on the pipeline deliver one error flag per result bit: sign in bit 31, exponent in bits 30..23 and fraction in bits 22..0. Each operation comes with a mode bit and a tag. In accurate mode any flagged bit calls for a replay. In approximate mode, flags on a programmable number of the lowest fraction bits are dropped, so their errors pass on without a recovery cost. The sign and exponent bits are checked in both modes.

The block decides by building a thermometer mask from the programmed count, clearing the masked flags and OR-reducing the rest. A positive decision produces a one-cycle replay request. This request is registered one cycle after the result strobe and carries the operation's tag. A small register port holds the mask count at address 0. It exposes a saturating count of suppressed errors at address 1, which is the count of operations whose only flagged bits were masked.

Top module: `fp_err_guard`

## Requirements
- R1: After reset the replay request is low, the mask count reads 0 at address 0 and the suppressed-error count reads 0 at address 1.
- R2: An operation with the mode bit low (accurate) that has any flag set in bits 31..0 raises the replay request.
- R3: An operation with the mode bit high (approximate) whose flags all lie in fraction bits below the mask count N (bits N-1..0) raises no replay request.
- R4: In approximate mode, a flag on a fraction bit at position N or above (up to bit 22) raises the replay request.
- R5: A flag on the sign bit (31) or on any exponent bit (30..23) raises the replay request in both modes.
- R6: A write to address 0 stores the written value as N, clamped to at most 23. Reading address 0 returns the stored N.
- R7: With N equal to 0, approximate mode gives the same replay decisions as accurate mode.
- R8: The replay request is high for exactly one cycle. That cycle follows the cycle in which the result strobe was high, and the tag output then equals that operation's tag. No request comes without a strobe, whatever the flags.
- R9: The count read at address 1 rises by one for each strobed operation with at least one flag and no replay. It holds at its all-ones maximum.
- R10: The mode is taken per operation. Operations on consecutive cycles with different mode bits are each judged by their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resValid | input | 1 | Result strobe, one cycle per operation |
| resApprox | input | 1 | Mode of the operation: 1 approximate, 0 accurate |
| resTag | input | TAG_W | Operation tag |
| errFlags | input | 32 | Per-bit timing-error flags of the result |
| cfgWe | input | 1 | Register write enable |
| cfgAddr | input | 1 | Register address: 0 mask count, 1 suppressed count |
| cfgWdata | input | CFG_W | Register write data |
| cfgRdata | output | CFG_W | Register read data for cfgAddr |
| replayReq | output | 1 | One-cycle replay request |
| replayTag | output | TAG_W | Tag of the operation to replay |

## Verification
The tests put single flags at the edges of the masked region: bit N-1 against bit N, bit 22 against bit 23, and bit 0 with N at zero. These patterns separate an off-by-one in the thermometer mask from a correct one. Sign-only and exponent-only flags in approximate mode with N at 23 show that the mask never reaches past the fraction. Back-to-back operations of opposite mode with identical flags show that the mode is sampled per operation and that each tag stays with its own decision. A strobe-free cycle with every flag set, followed by a long run of masked errors against a small counter width, covers the gating and the saturation.

// File: rtl/fp_err_guard_pkg.sv
`timescale 1ns/1ps
package fp_err_guard_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic evalStb;    // an operation is being judged this cycle
    logic wrMaskLen;  // load a new mask count
    logic countSup;   // a masked-only error was seen
  } guardStrobes_t;
endpackage

// File: rtl/fp_err_guard_dp.sv
`timescale 1ns/1ps
module fp_err_guard_dp
  import fp_err_guard_pkg::*;
#(
  parameter int FRAC_W = 23,
  parameter int EXP_W  = 8,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  guardStrobes_t              strobes,
  input  logic                       resApprox,
  input  logic [TAG_W-1:0]           resTag,
  input  logic [FRAC_W+EXP_W:0]      errFlags,
  input  logic                       cfgAddr,
  input  logic [CFG_W-1:0]           cfgWdata,
  output logic                       anyErr,
  output logic                       keepErr,
  output logic [CFG_W-1:0]           cfgRdata,
  output logic [TAG_W-1:0]           replayTag
);
  localparam int WORD_W = FRAC_W + EXP_W + 1;
  localparam int N_W    = $clog2(FRAC_W + 1);
  localparam int HDR_W  = WORD_W - FRAC_W;

  logic [N_W-1:0]    maskLen;
  logic [CNT_W-1:0]  supCnt;
  logic [FRAC_W-1:0] lowMask;
  logic [WORD_W-1:0] keepVec;
  logic [N_W-1:0]    wrLen;

  // Thermometer code: fraction bit i is masked when i < maskLen
  for (genvar i = 0; i < FRAC_W; i++) begin : g_therm
    assign lowMask[i] = (maskLen > N_W'(i));
  end

  assign keepVec = errFlags & ~{{HDR_W{1'b0}}, lowMask & {FRAC_W{resApprox}}};
  assign anyErr  = |errFlags;
  assign keepErr = |keepVec;

  assign wrLen = (cfgWdata > CFG_W'(FRAC_W)) ? N_W'(FRAC_W) : cfgWdata[N_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskLen   <= '0;
      supCnt    <= '0;
      replayTag <= '0;
    end else begin
      if (strobes.wrMaskLen) maskLen <= wrLen;
      if (strobes.countSup && supCnt != {CNT_W{1'b1}}) supCnt <= supCnt + 1'b1;
      if (strobes.evalStb) replayTag <= resTag;
    end
  end

  always_comb begin
    if (cfgAddr) cfgRdata = CFG_W'(supCnt);
    else         cfgRdata = CFG_W'(maskLen);
  end

  // R6: stored count never exceeds the fraction width
  p_len_clamped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    maskLen <= N_W'(FRAC_W));

  // R9: counter only moves up by one
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(supCnt) |-> supCnt == $past(supCnt) + 1'b1);

  // R5: header flags are never masked
  p_hdr_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|errFlags[WORD_W-1:FRAC_W]) |-> keepErr);
endmodule

// File: rtl/fp_err_guard_ctl.sv
`timescale 1ns/1ps
module fp_err_guard_ctl
  import fp_err_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resValid,
  input  logic          cfgWe,
  input  logic          cfgAddr,
  input  logic          anyErr,
  input  logic          keepErr,
  output guardStrobes_t strobes,
  output logic          replayReq
);
  always_comb begin
    strobes.evalStb   = resValid;
    strobes.wrMaskLen = cfgWe && !cfgAddr;
    strobes.countSup  = resValid && anyErr && !keepErr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) replayReq <= 1'b0;
    else        replayReq <= resValid && keepErr;
  end

  // R8: a request always follows a strobe
  p_req_after_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    replayReq |-> $past(resValid));

  // R9: a suppressed count never coincides with a replay decision
  p_sup_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.countSup |=> !replayReq);
endmodule

// File: rtl/fp_err_guard.sv
`timescale 1ns/1ps
module fp_err_guard
  import fp_err_guard_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int CNT_W = 16,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resValid,
  input  logic             resApprox,
  input  logic [TAG_W-1:0] resTag,
  input  logic [31:0]      errFlags,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             replayReq,
  output logic [TAG_W-1:0] replayTag
);
  localparam int FRAC_W = 23;
  localparam int EXP_W  = 8;

  guardStrobes_t strobes;
  logic anyErr, keepErr;

  fp_err_guard_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .resValid(resValid), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .anyErr(anyErr), .keepErr(keepErr),
    .strobes(strobes), .replayReq(replayReq)
  );

  fp_err_guard_dp #(
    .FRAC_W(FRAC_W), .EXP_W(EXP_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .CFG_W(CFG_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .resApprox(resApprox),
    .resTag(resTag), .errFlags(errFlags), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .anyErr(anyErr), .keepErr(keepErr), .cfgRdata(cfgRdata), .replayTag(replayTag)
  );

  // R2: accurate mode replays on any flag
  p_accurate_replay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && !resApprox && (|errFlags) |=> replayReq);

  // R5: sign or exponent flag replays in either mode
  p_hdr_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && (|errFlags[31:23]) |=> replayReq);

  // R8: request carries the strobed tag
  p_tag_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> replayTag == $past(resTag));

  // R8: clean results never replay
  p_clean_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && errFlags == 32'd0 |=> !replayReq);
endmodule

// File: tb/fp_err_guard_tb.sv
`timescale 1ns/1ps
module fp_err_guard_tb;
  localparam int TAG_W = 4;
  localparam int CNT_W = 4;
  localparam int CFG_W = 32;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resValid = 1'b0, resApprox = 1'b0;
  logic [TAG_W-1:0] resTag = '0;
  logic [31:0] errFlags = '0;
  logic cfgWe = 1'b0, cfgAddr = 1'b0;
  logic [CFG_W-1:0] cfgWdata = '0;
  logic [CFG_W-1:0] cfgRdata;
  logic replayReq;
  logic [TAG_W-1:0] replayTag;

  int testsRun = 0, testsFailed = 0;
  int curN = 0, expCnt = 0;

  always #4 clk = ~clk;

  fp_err_guard #(.TAG_W(TAG_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .resValid(resValid), .resApprox(resApprox),
    .resTag(resTag), .errFlags(errFlags), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .replayReq(replayReq),
    .replayTag(replayTag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expReplay(input bit approx, input logic [31:0] f, input int n);
    logic [31:0] m;
    m = approx ? ((32'd1 << n) - 32'd1) : 32'd0;
    return (f & ~m) != 32'd0;
  endfunction

  function automatic void bookCount(input bit approx, input logic [31:0] f);
    if (f != 0 && !expReplay(approx, f, curN) && expCnt < CNT_MAX) expCnt++;
  endfunction

  task automatic cfgWrite(input logic [CFG_W-1:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 1'b0; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
    curN = (v > 23) ? 23 : int'(v);
  endtask

  task automatic readCheck(input bit addr, input int exp, input string req);
    cfgAddr = addr;
    #1;
    check(cfgRdata == CFG_W'(exp), req, int'(cfgRdata), exp);
  endtask

  // One strobed operation, checked for decision, tag and pulse width
  task automatic runOp(input bit approx, input logic [31:0] f, input logic [TAG_W-1:0] tag,
                       input string req);
    bit e;
    @(negedge clk);
    resValid = 1'b1; resApprox = approx; errFlags = f; resTag = tag;
    e = expReplay(approx, f, curN);
    bookCount(approx, f);
    @(negedge clk);
    resValid = 1'b0; errFlags = '0;
    check(replayReq == e, req, int'(replayReq), int'(e));
    if (e) check(replayTag == tag, {req, " R8 tag"}, int'(replayTag), int'(tag));
    @(negedge clk);
    check(replayReq == 1'b0, {req, " R8 pulse"}, int'(replayReq), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(replayReq == 1'b0, "R1 req", int'(replayReq), 0);
    readCheck(1'b0, 0, "R1 len");
    readCheck(1'b1, 0, "R1 cnt");
  endtask

  task automatic t_accurate;
    runOp(1'b0, 32'h0000_0001, 4'h1, "R2 bit0");
    runOp(1'b0, 32'h0040_0000, 4'h2, "R2 bit22");
    runOp(1'b0, 32'h0000_0000, 4'h3, "R8 clean");
    readCheck(1'b1, expCnt, "R9 no count in accurate");
  endtask

  task automatic t_clamp;
    cfgWrite(40);  readCheck(1'b0, 23, "R6 clamp 40");
    cfgWrite(23);  readCheck(1'b0, 23, "R6 exact 23");
    cfgWrite(5);   readCheck(1'b0, 5, "R6 value 5");
  endtask

  task automatic t_approx;
    cfgWrite(5);
    runOp(1'b1, 32'h0000_0010, 4'h4, "R3 bit4 masked");
    runOp(1'b1, 32'h0000_0009, 4'h5, "R3 bits0,3 masked");
    runOp(1'b1, 32'h0000_0020, 4'h6, "R4 bit5 kept");
    runOp(1'b1, 32'h0000_0030, 4'h7, "R4 mixed bits4,5");
    readCheck(1'b1, expCnt, "R9 count after N=5");
    cfgWrite(23);
    runOp(1'b1, 32'h0040_0000, 4'h8, "R3 bit22 masked N=23");
    runOp(1'b1, 32'h0080_0000, 4'h9, "R5 exp bit23");
    runOp(1'b1, 32'h8000_0000, 4'hA, "R5 sign bit31");
    runOp(1'b0, 32'h4000_0000, 4'hB, "R5 exp bit30 accurate");
    readCheck(1'b1, expCnt, "R9 count after N=23");
  endtask

  task automatic t_zero;
    cfgWrite(0);
    runOp(1'b1, 32'h0000_0001, 4'hC, "R7 bit0 N=0");
    runOp(1'b1, 32'h0000_0000, 4'hD, "R7 clean N=0");
    readCheck(1'b1, expCnt, "R7 no count N=0");
  endtask

  task automatic t_mixed;
    cfgWrite(10);
    @(negedge clk);
    resValid = 1'b1; resApprox = 1'b1; errFlags = 32'h8; resTag = 4'h1;
    bookCount(1'b1, 32'h8);
    @(negedge clk);
    check(replayReq == 1'b0, "R10 approx first", int'(replayReq), 0);
    resApprox = 1'b0; resTag = 4'h2;
    bookCount(1'b0, 32'h8);
    @(negedge clk);
    resValid = 1'b0; errFlags = '0;
    check(replayReq == 1'b1, "R10 accurate second", int'(replayReq), 1);
    check(replayTag == 4'h2, "R10 tag second", int'(replayTag), 2);
    @(negedge clk);
    check(replayReq == 1'b0, "R10 pulse ends", int'(replayReq), 0);
    readCheck(1'b1, expCnt, "R10 count");
  endtask

  task automatic t_novalid;
    @(negedge clk);
    errFlags = 32'hFFFF_FFFF; resApprox = 1'b0;
    @(negedge clk);
    check(replayReq == 1'b0, "R8 no strobe", int'(replayReq), 0);
    errFlags = '0;
    readCheck(1'b1, expCnt, "R8 no strobe count");
  endtask

  task automatic t_saturate;
    cfgWrite(23);
    for (int k = 0; k < 20; k++) runOp(1'b1, 32'h0000_0100, TAG_W'(k), "R9 masked run");
    readCheck(1'b1, CNT_MAX, "R9 saturate");
  endtask

  initial begin
    #(8 * 200000);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_accurate();
    t_clamp();
    t_approx();
    t_zero();
    t_mixed();
    t_novalid();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule